// File: doc/BRIEF.md
# Reset and Sleep Controller

This block decides when the core of a small 8-bit microcontroller is held in reset, when it is halted in low-power sleep, and what the two status flags, watchdog-expired (`to_flag`) and not-powered-down (`pd_flag`), say about the most recent reset or wake. It takes the power-on indication, the external master-clear pin, the watchdog time-out strobe, and the strobes the core raises when it executes its sleep and watchdog-clear instructions.

After power-on, the core stays in reset until the master-clear pin is high and a startup period has passed. That period is counted in pulses of a slow tick, with a default of 18 ticks of 1 ms. A master-clear or a watchdog time-out resets the core at any later time. Each of them also ends sleep, and the flags record which of the four cases happened. The block also presents the reset load values that the core copies into its program counter, its port direction register and the upper bits of its status register.

Top module: `rst_sleep_ctrl`

## Requirements
- R1: While `por_n` is low, `core_rst` is 1, `to_flag` is 1, `pd_flag` is 1 and `asleep` is 0.
- R2: After `por_n` rises, `core_rst` stays 1 while `mclr_n` is low. Once `mclr_n` is high, `core_rst` stays 1 until `START_TICKS` pulses of `slow_tick` have been counted, then it falls synchronously.
- R3: `pc_rst_val` is all ones, `dir_rst_val` is all ones (every pin an input), and `status_hi_rst` is 3'b000.
- R4: An accepted `clrwdt_req` sets `to_flag`=1 and `pd_flag`=1 on the next clock, and raises `wdt_clr` in the same cycle as the request.
- R5: An accepted `sleep_req` sets `asleep`=1, `to_flag`=1 and `pd_flag`=0, drops `core_clk_en`, and raises `wdt_clr` in the request cycle.
- R6: `wdt_timeout` while awake makes `core_rst` 1 for exactly one cycle after the strobe, with `to_flag`=0 and `pd_flag`=1.
- R7: `wdt_timeout` while asleep wakes the block (`asleep`=0, `core_clk_en`=1 afterwards) through a one-cycle reset, with `to_flag`=0 and `pd_flag`=0.
- R8: `mclr_n` low while awake holds `core_rst` at 1, after a two-flop synchronizer, for as long as the pin is low, and leaves `to_flag` and `pd_flag` unchanged. Reset is released a few cycles after the pin rises.
- R9: `mclr_n` falling while asleep ends sleep and resets the core, with `to_flag`=1 and `pd_flag`=0.
- R10: `sleep_req` and `clrwdt_req` are ignored while `asleep` or `core_rst` is 1. They raise no `wdt_clr` and change neither flag nor `asleep`.
- R11: A watchdog time-out beats both instruction strobes in the same cycle. With `clrwdt_req` alongside, the result is `to_flag`=0 and `pd_flag`=1. With `sleep_req` alongside, `asleep` stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| por_n | input | 1 | Power-on indication, active low, asynchronous |
| mclr_n | input | 1 | Master-clear pin, active low, asynchronous |
| slow_tick | input | 1 | One-cycle pulse that paces the startup timer |
| wdt_timeout | input | 1 | One-cycle watchdog expiry strobe |
| sleep_req | input | 1 | Core executed the sleep instruction |
| clrwdt_req | input | 1 | Core executed the watchdog-clear instruction |
| core_rst | output | 1 | Core reset, active high |
| core_clk_en | output | 1 | Core clock enable, low while asleep |
| asleep | output | 1 | Sleep state |
| wdt_clr | output | 1 | Clear pulse to the watchdog counter |
| to_flag | output | 1 | Status flag: 0 after a watchdog expiry |
| pd_flag | output | 1 | Status flag: 0 after entering sleep |
| pc_rst_val | output | PC_W | Program counter reset value |
| dir_rst_val | output | DIR_W | Port direction register reset value |
| status_hi_rst | output | 3 | Reset value of the upper status bits |

## Verification
The assertions assume that `wdt_timeout`, `sleep_req` and `clrwdt_req` are single-cycle strobes synchronous to `clk`. They also assume that `slow_tick` is a one-cycle pulse, and that `por_n` is released only while the clock runs. The stimulus drives every strobe for exactly one clock, always on the falling edge. It holds `mclr_n` steady for many cycles at a time, so the synchronizer never sees a glitch shorter than its two stages. Simultaneous strobes are applied only in the priority cases of R11.

// File: rtl/rsc_pkg.sv
package rsc_pkg;

  typedef enum logic [2:0] {
    EV_NONE,
    EV_CLRWDT,
    EV_SLEEP,
    EV_MCLR_RUN,
    EV_MCLR_SLEEP,
    EV_WDT_RUN,
    EV_WDT_SLEEP
  } rsc_event_e;

  typedef struct packed {
    logic to;
    logic pd;
  } rsc_flags_t;

  // Watchdog beats master-clear, which beats the instruction strobes.
  function automatic rsc_event_e pick_event(input logic wdt, input logic mfall,
                                            input logic sleeping, input logic sl_ok,
                                            input logic cw_ok);
    if (wdt)   return sleeping ? EV_WDT_SLEEP : EV_WDT_RUN;
    if (mfall) return sleeping ? EV_MCLR_SLEEP : EV_MCLR_RUN;
    if (sl_ok) return EV_SLEEP;
    if (cw_ok) return EV_CLRWDT;
    return EV_NONE;
  endfunction

  function automatic rsc_flags_t next_flags(input rsc_event_e ev, input rsc_flags_t cur);
    rsc_flags_t n;
    case (ev)
      EV_CLRWDT:     n = '{to: 1'b1, pd: 1'b1};
      EV_SLEEP:      n = '{to: 1'b1, pd: 1'b0};
      EV_MCLR_SLEEP: n = '{to: 1'b1, pd: 1'b0};
      EV_WDT_RUN:    n = '{to: 1'b0, pd: 1'b1};
      EV_WDT_SLEEP:  n = '{to: 1'b0, pd: 1'b0};
      default:       n = cur;
    endcase
    return n;
  endfunction

endpackage

// File: rtl/rsc_sync.sv
module rsc_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain <= '0;
    else        chain <= {chain[STAGES-2:0], d};
  end

  assign q = chain[STAGES-1];
endmodule

// File: rtl/rsc_startup.sv
module rsc_startup #(
  parameter int TICKS = 18
) (
  input  logic clk,
  input  logic por_n,
  input  logic pin_ok,
  input  logic tick,
  output logic hold
);
  localparam int CW = $clog2(TICKS + 1);
  localparam logic [CW-1:0] LAST = CW'(TICKS);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n)                      cnt <= '0;
    else if (pin_ok && tick && hold) cnt <= cnt + 1'b1;
  end

  assign hold = (cnt != LAST);
endmodule

// File: rtl/rsc_flags.sv
module rsc_flags
  import rsc_pkg::*;
(
  input  logic clk,
  input  logic por_n,
  input  logic wdt_timeout,
  input  logic mclr_fall,
  input  logic sleep_req,
  input  logic clrwdt_req,
  input  logic in_reset,
  output logic to_flag,
  output logic pd_flag,
  output logic asleep,
  output logic sleep_acc,
  output logic clr_acc
);
  rsc_flags_t flags;
  rsc_event_e ev;
  logic       sleeping;
  logic       blocked;

  assign blocked   = in_reset | sleeping | wdt_timeout | mclr_fall;
  assign sleep_acc = sleep_req & ~blocked;
  assign clr_acc   = clrwdt_req & ~blocked & ~sleep_req;
  assign ev        = pick_event(wdt_timeout, mclr_fall, sleeping, sleep_acc, clr_acc);

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) begin
      flags    <= '{to: 1'b1, pd: 1'b1};
      sleeping <= 1'b0;
    end else begin
      flags <= next_flags(ev, flags);
      if (ev == EV_SLEEP)                sleeping <= 1'b1;
      else if (wdt_timeout || mclr_fall) sleeping <= 1'b0;
    end
  end

  assign to_flag = flags.to;
  assign pd_flag = flags.pd;
  assign asleep  = sleeping;
endmodule

// File: rtl/rst_sleep_ctrl.sv
module rst_sleep_ctrl #(
  parameter int START_TICKS = 18,
  parameter int PC_W        = 11,
  parameter int DIR_W       = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             por_n,
  input  logic             mclr_n,
  input  logic             slow_tick,
  input  logic             wdt_timeout,
  input  logic             sleep_req,
  input  logic             clrwdt_req,
  output logic             core_rst,
  output logic             core_clk_en,
  output logic             asleep,
  output logic             wdt_clr,
  output logic             to_flag,
  output logic             pd_flag,
  output logic [PC_W-1:0]  pc_rst_val,
  output logic [DIR_W-1:0] dir_rst_val,
  output logic [2:0]       status_hi_rst
);
  logic mclr_s;
  logic mclr_prev;
  logic mclr_fall;
  logic startup_hold;
  logic rst_q;
  logic sleep_acc;
  logic clr_acc;

  rsc_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(por_n), .d(mclr_n), .q(mclr_s)
  );

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) mclr_prev <= 1'b0;
    else        mclr_prev <= mclr_s;
  end
  assign mclr_fall = mclr_prev & ~mclr_s;

  rsc_startup #(.TICKS(START_TICKS)) u_start (
    .clk(clk), .por_n(por_n), .pin_ok(mclr_s), .tick(slow_tick), .hold(startup_hold)
  );

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) rst_q <= 1'b1;
    else        rst_q <= startup_hold | ~mclr_s | wdt_timeout;
  end

  rsc_flags u_flags (
    .clk(clk), .por_n(por_n), .wdt_timeout(wdt_timeout), .mclr_fall(mclr_fall),
    .sleep_req(sleep_req), .clrwdt_req(clrwdt_req), .in_reset(rst_q),
    .to_flag(to_flag), .pd_flag(pd_flag), .asleep(asleep),
    .sleep_acc(sleep_acc), .clr_acc(clr_acc)
  );

  assign core_rst      = rst_q;
  assign core_clk_en   = ~asleep;
  assign wdt_clr       = sleep_acc | clr_acc;
  assign pc_rst_val    = '1;
  assign dir_rst_val   = '1;
  assign status_hi_rst = 3'b000;
endmodule

// File: rtl/rsc_chk.sv
module rsc_chk (
  input logic clk,
  input logic por_n,
  input logic wdt_timeout,
  input logic mclr_fall,
  input logic sleep_acc,
  input logic clr_acc,
  input logic startup_hold,
  input logic core_rst,
  input logic core_clk_en,
  input logic asleep,
  input logic to_flag,
  input logic pd_flag
);
  AST_STARTUP_HOLD: assert property (@(posedge clk) disable iff (!por_n)
    startup_hold |=> core_rst); // R2
  AST_CLR_FLAGS: assert property (@(posedge clk) disable iff (!por_n)
    clr_acc |=> (to_flag && pd_flag)); // R4
  AST_SLEEP_ENTRY: assert property (@(posedge clk) disable iff (!por_n)
    sleep_acc |=> (asleep && to_flag && !pd_flag && !core_clk_en)); // R5
  AST_WDT_RESET: assert property (@(posedge clk) disable iff (!por_n)
    wdt_timeout |=> (core_rst && !to_flag && !asleep)); // R6
  AST_WDT_RUN_PD: assert property (@(posedge clk) disable iff (!por_n)
    (wdt_timeout && !asleep) |=> pd_flag); // R6
  AST_WDT_WAKE_PD: assert property (@(posedge clk) disable iff (!por_n)
    (wdt_timeout && asleep) |=> !pd_flag); // R7
  AST_MCLR_WAKE: assert property (@(posedge clk) disable iff (!por_n)
    (mclr_fall && asleep && !wdt_timeout) |=> (to_flag && !pd_flag && !asleep && core_rst)); // R9
  AST_FLAGS_QUIET: assert property (@(posedge clk) disable iff (!por_n)
    (!wdt_timeout && !mclr_fall && !sleep_acc && !clr_acc) |=> ($stable(to_flag) && $stable(pd_flag))); // R10
endmodule

bind rst_sleep_ctrl rsc_chk u_chk (
  .clk(clk), .por_n(por_n), .wdt_timeout(wdt_timeout), .mclr_fall(mclr_fall),
  .sleep_acc(sleep_acc), .clr_acc(clr_acc), .startup_hold(startup_hold),
  .core_rst(core_rst), .core_clk_en(core_clk_en), .asleep(asleep),
  .to_flag(to_flag), .pd_flag(pd_flag)
);

// File: tb/tb_rst_sleep_ctrl.sv
module tb_rst_sleep_ctrl;
  logic clk = 1'b0;
  logic por_n = 1'b0, mclr_n = 1'b0, slow_tick = 1'b0;
  logic wdt_timeout = 1'b0, sleep_req = 1'b0, clrwdt_req = 1'b0;
  logic core_rst, core_clk_en, asleep, wdt_clr, to_flag, pd_flag;
  logic [10:0] pc_rst_val;
  logic [7:0]  dir_rst_val;
  logic [2:0]  status_hi_rst;

  int checks = 0;
  int errors = 0;

  always #10 clk = ~clk;

  rst_sleep_ctrl dut (
    .clk(clk), .por_n(por_n), .mclr_n(mclr_n), .slow_tick(slow_tick),
    .wdt_timeout(wdt_timeout), .sleep_req(sleep_req), .clrwdt_req(clrwdt_req),
    .core_rst(core_rst), .core_clk_en(core_clk_en), .asleep(asleep), .wdt_clr(wdt_clr),
    .to_flag(to_flag), .pd_flag(pd_flag), .pc_rst_val(pc_rst_val),
    .dir_rst_val(dir_rst_val), .status_hi_rst(status_hi_rst)
  );

  // slow tick: one cycle in four
  initial begin
    forever begin
      repeat (3) @(negedge clk);
      slow_tick = 1'b1;
      @(negedge clk);
      slow_tick = 1'b0;
    end
  end

  // scoreboard; vector bits: [5]rst [4]to [3]pd [2]asleep [1]clk_en [0]wdt_clr
  typedef struct {
    string      tag;
    logic [5:0] exp;
    logic [5:0] mask;
  } sb_item_t;
  sb_item_t sb_q[$];
  event     sb_ev;

  task automatic expect_out(input string tag, input logic [5:0] exp, input logic [5:0] mask);
    sb_item_t it;
    it.tag = tag; it.exp = exp; it.mask = mask;
    sb_q.push_back(it);
    -> sb_ev;
    #1;
  endtask

  initial begin
    forever begin
      @(sb_ev);
      while (sb_q.size() != 0) begin
        sb_item_t it;
        logic [5:0] obs;
        it  = sb_q.pop_front();
        obs = {core_rst, to_flag, pd_flag, asleep, core_clk_en, wdt_clr};
        checks++;
        if ((obs & it.mask) !== (it.exp & it.mask)) begin
          errors++;
          $display("FAIL %s act=%b exp=%b mask=%b", it.tag, obs, it.exp, it.mask);
        end
      end
    end
  end

  task automatic check_val(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  // one-cycle strobe; wdt_clr is checked while the strobe is high
  task automatic strobe(input logic w, input logic s, input logic c,
                        input logic exp_clr, input string tag);
    @(negedge clk);
    wdt_timeout = w; sleep_req = s; clrwdt_req = c;
    #2;
    expect_out(tag, {5'b0, exp_clr}, 6'b000001);
    @(negedge clk);
    wdt_timeout = 1'b0; sleep_req = 1'b0; clrwdt_req = 1'b0;
  endtask

  task automatic finish_run();
    #1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    #(200000 * 20);
    errors++;
    $display("FAIL watchdog expired before the sequence ended");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    expect_out("R1 power-on state", 6'b111000, 6'b111100);
    check_val("R3 pc reset value", 32'(pc_rst_val), 32'h7FF);
    check_val("R3 direction reset value", 32'(dir_rst_val), 32'hFF);
    check_val("R3 status high bits", 32'(status_hi_rst), 32'h0);

    // R2: startup waits for the pin and then for the ticks
    @(negedge clk); por_n = 1'b1;
    repeat (60) @(negedge clk);
    expect_out("R2 held while pin low", 6'b100000, 6'b100000);
    mclr_n = 1'b1;
    repeat (30) @(negedge clk);
    expect_out("R2 held during startup count", 6'b100000, 6'b100000);
    repeat (100) @(negedge clk);
    expect_out("R2 released after startup", 6'b011010, 6'b111110);

    // R6: watchdog while running
    strobe(1'b1, 1'b0, 1'b0, 1'b0, "R6 no clear pulse");
    expect_out("R6 watchdog reset flags", 6'b101000, 6'b111100);
    @(negedge clk);
    expect_out("R6 reset lasts one cycle", 6'b001000, 6'b111100);

    // R4: clear watchdog instruction
    strobe(1'b0, 1'b0, 1'b1, 1'b1, "R4 clear pulse");
    expect_out("R4 flags set", 6'b011000, 6'b111100);

    // R5: sleep
    strobe(1'b0, 1'b1, 1'b0, 1'b1, "R5 clear pulse");
    expect_out("R5 asleep", 6'b010100, 6'b111110);

    // R10: strobes while asleep are ignored
    strobe(1'b0, 1'b0, 1'b1, 1'b0, "R10 no pulse asleep");
    expect_out("R10 flags unchanged asleep", 6'b010100, 6'b111110);
    strobe(1'b0, 1'b1, 1'b0, 1'b0, "R10 no sleep pulse asleep");

    // R7: watchdog wake
    strobe(1'b1, 1'b0, 1'b0, 1'b0, "R7 no clear pulse");
    expect_out("R7 wake reset flags", 6'b100010, 6'b111110);
    @(negedge clk);
    expect_out("R7 running after wake", 6'b000010, 6'b111110);

    // R8: master-clear while awake (flags now to=0 pd=0)
    @(negedge clk); mclr_n = 1'b0;
    repeat (4) @(negedge clk);
    expect_out("R8 held, flags kept", 6'b100000, 6'b111100);
    strobe(1'b0, 1'b1, 1'b0, 1'b0, "R10 sleep ignored in reset");
    strobe(1'b0, 1'b0, 1'b1, 1'b0, "R10 clear ignored in reset");
    expect_out("R10 flags kept in reset", 6'b100000, 6'b111100);
    repeat (10) @(negedge clk);
    expect_out("R8 still held", 6'b100000, 6'b100000);
    mclr_n = 1'b1;
    repeat (5) @(negedge clk);
    expect_out("R8 released", 6'b000010, 6'b111110);

    // R9: master-clear wake
    strobe(1'b0, 1'b1, 1'b0, 1'b1, "R5 clear pulse again");
    expect_out("R5 asleep again", 6'b010100, 6'b111110);
    mclr_n = 1'b0;
    repeat (4) @(negedge clk);
    expect_out("R9 wake by pin", 6'b110010, 6'b111110);
    mclr_n = 1'b1;
    repeat (5) @(negedge clk);
    expect_out("R9 running after pin", 6'b010010, 6'b111110);

    // R11: priority of the watchdog
    strobe(1'b1, 1'b0, 1'b1, 1'b0, "R11 clear suppressed");
    expect_out("R11 watchdog beats clear", 6'b101000, 6'b111100);
    repeat (2) @(negedge clk);
    strobe(1'b1, 1'b1, 1'b0, 1'b0, "R11 sleep suppressed");
    expect_out("R11 watchdog beats sleep", 6'b101010, 6'b111110);
    repeat (2) @(negedge clk);
    finish_run();
  end
endmodule